// File: doc/BRIEF.md
# Bipolar Violation and Excess Zeros Detector

This block watches a received alternate-mark-inversion line. Each bit time is given as two rail bits, one for a positive mark and one for a negative mark, and is qualified by a clock enable. The block tracks the polarity of the last mark. It reports a bipolar violation when a mark has the same polarity as the mark before it. It reports an excess-zeros event when a run of zeros that follows a mark grows long enough. Both results leave the block as single-cycle strobes, ready to drive an error counter.

The zero-substitution codes put deliberate violations on the line. Those violations are not errors, so the block can recognise them. A configuration code selects plain AMI, the eight-zero substitution used on T1 lines, or the three-zero substitution used on E1 lines. To recognise the eight-zero pattern, the block must see symbols that arrive after the violation. Every violation therefore passes through a look-ahead window of eight bit times before it is reported. A further strobe combines violations with, optionally, excess-zeros events, to feed a line-code-violation count.

Top module: `bpvx_detect`

## Requirements
- R1: A mark whose polarity equals that of the previous mark raises `bpv_o` for one cycle. The strobe appears in the cycle after the eighth enabled clock edge that follows the edge on which the violating mark was sampled. The first mark after reset is never a violation.
- R2: Both rails high in one bit time is a violation. It is never excused as substitution, and it leaves the stored polarity of the last mark unchanged.
- R3: With `code_sel` = 1 (eight-zero substitution), the 8-symbol group 0,0,0,V,B,0,V,B produces no `bpv_o`. Here V is a mark with the same polarity as the previous mark and B is a mark of alternating polarity.
- R4: With `code_sel` = 2 (three-zero substitution), the groups 0,0,0,V and B,0,0,V produce no `bpv_o` for their V.
- R5: With `code_sel` = 0 (or 3), no group is excused, and every same-polarity mark is reported.
- R6: `exz_o` pulses in the cycle after the enabled edge that samples the Nth consecutive zero following a mark. N is 8 when `exz_16` = 0 and 16 when `exz_16` = 1.
- R7: `exz_o` pulses at most once per zero run. It pulses again only after a new mark starts a new run.
- R8: Zeros received after reset and before the first mark never raise `exz_o`.
- R9: `lcv_o` pulses whenever `bpv_o` pulses. It also pulses together with `exz_o` when `exz_to_lcv` = 1. It never pulses otherwise.
- R10: All three strobes are low during reset and in any cycle that does not follow an enabled clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One bit time is present on the rails |
| pos_in | input | 1 | Positive-mark rail |
| neg_in | input | 1 | Negative-mark rail |
| code_sel | input | 2 | 0/3 AMI, 1 eight-zero substitution, 2 three-zero substitution |
| exz_16 | input | 1 | Zero-run threshold: 0 gives 8, 1 gives 16 |
| exz_to_lcv | input | 1 | Fold excess-zeros events into `lcv_o` |
| bpv_o | output | 1 | Bipolar violation strobe |
| exz_o | output | 1 | Excess-zeros strobe |
| lcv_o | output | 1 | Line-code-violation strobe |

## Verification
The assertions assume three things about the inputs. The rails carry meaning only in cycles where `bit_en` is high. The substitution code and the zero threshold stay fixed for the length of a zero run or a substitution group. Reset is applied before the rails are first used. The bench changes configuration only while reset is held. It drives the rails and `bit_en` on the falling clock edge, and drops `bit_en` for one cycle after every symbol, so every strobe must fall back low before the next edge.

// File: rtl/bpvx_pkg.sv
package bpvx_pkg;

  typedef enum logic [1:0] {
    POL_NONE = 2'd0,
    POL_POS  = 2'd1,
    POL_NEG  = 2'd2
  } pol_t;

  localparam logic [1:0] CODE_AMI  = 2'd0;
  localparam logic [1:0] CODE_EIGHT = 2'd1;
  localparam logic [1:0] CODE_THREE = 2'd2;

  // one classified bit time
  typedef struct packed {
    logic mark;   // a pulse was present
    logic viol;   // same polarity as the previous mark, or both rails
    logic hard;   // both rails: never excusable
  } sym_t;

endpackage

// File: rtl/bpvx_mark_class.sv
module bpvx_mark_class
  import bpvx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic pos_in,
  input  logic neg_in,
  output sym_t sym_o
);

  pol_t last_pol;

  always_comb begin
    sym_o.mark = pos_in | neg_in;
    sym_o.hard = pos_in & neg_in;
    sym_o.viol = (pos_in & neg_in)
               | (pos_in & ~neg_in & (last_pol == POL_POS))
               | (neg_in & ~pos_in & (last_pol == POL_NEG));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_pol <= POL_NONE;
    end else if (bit_en && (pos_in ^ neg_in)) begin
      last_pol <= pos_in ? POL_POS : POL_NEG;
    end
  end

  // R1: polarity history follows single-rail marks
  assert_pos_tracked_R1: assert property (@(posedge clk) disable iff (rst)
    (bit_en && pos_in && !neg_in) |=> (last_pol == POL_POS));
  assert_neg_tracked_R1: assert property (@(posedge clk) disable iff (rst)
    (bit_en && neg_in && !pos_in) |=> (last_pol == POL_NEG));
  // R2: a double-rail bit time leaves history alone
  assert_double_keeps_pol_R2: assert property (@(posedge clk) disable iff (rst)
    (bit_en && pos_in && neg_in) |=> $stable(last_pol));

endmodule

// File: rtl/bpvx_sub_window.sv
module bpvx_sub_window
  import bpvx_pkg::*;
#(
  parameter int LOOKAHEAD = 8   // must be at least 8 for the eight-zero group
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_en,
  input  logic [1:0] code_sel,
  input  sym_t       sym_new,
  output logic       tail_viol
);

  localparam int LAST = LOOKAHEAD - 1;

  sym_t line_q [LOOKAHEAD];
  sym_t win    [LOOKAHEAD];
  sym_t win_x  [LOOKAHEAD];

  function automatic logic is_z(sym_t s);
    return !s.mark;
  endfunction
  function automatic logic is_b(sym_t s);
    return s.mark && !s.viol;
  endfunction
  function automatic logic is_v(sym_t s);
    return s.viol && !s.hard;
  endfunction

  // candidate window, index 0 newest
  assign win[0] = sym_new;
  for (genvar i = 1; i < LOOKAHEAD; i++) begin : g_shift
    assign win[i] = line_q[i-1];
  end

  logic hit_eight, hit_three_a, hit_three_b;

  always_comb begin
    hit_eight   = (code_sel == CODE_EIGHT)
                && is_b(win[0]) && is_v(win[1]) && is_z(win[2]) && is_b(win[3])
                && is_v(win[4]) && is_z(win[5]) && is_z(win[6]) && is_z(win[7]);
    hit_three_a = (code_sel == CODE_THREE)
                && is_v(win[0]) && is_z(win[1]) && is_z(win[2]) && is_z(win[3]);
    hit_three_b = (code_sel == CODE_THREE)
                && is_v(win[0]) && is_z(win[1]) && is_z(win[2]) && is_b(win[3]);
  end

  always_comb begin
    for (int i = 0; i < LOOKAHEAD; i++) win_x[i] = win[i];
    if (hit_eight) begin
      win_x[1].viol = 1'b0;
      win_x[4].viol = 1'b0;
    end
    if (hit_three_a || hit_three_b) begin
      win_x[0].viol = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LOOKAHEAD; i++) line_q[i] <= '0;
    end else if (bit_en) begin
      for (int i = 0; i < LOOKAHEAD; i++) line_q[i] <= win_x[i];
    end
  end

  assign tail_viol = line_q[LAST].viol;

  // R2: a double-rail entry keeps its violation all the way out
  assert_hard_kept_R2: assert property (@(posedge clk) disable iff (rst)
    line_q[LAST].hard |-> line_q[LAST].viol);
  // R1: a zero never leaves the window flagged
  assert_zero_clean_R1: assert property (@(posedge clk) disable iff (rst)
    (!line_q[LAST].mark) |-> !line_q[LAST].viol);
  // R3: both substituted pulses are cleared once the group completes
  assert_eight_cleared_R3: assert property (@(posedge clk) disable iff (rst)
    (bit_en && hit_eight) |=> (!line_q[1].viol && !line_q[4].viol));
  // R4: substituted pulse of the three-zero code is stored clean
  assert_three_cleared_R4: assert property (@(posedge clk) disable iff (rst)
    (bit_en && (hit_three_a || hit_three_b)) |=> !line_q[0].viol);

endmodule

// File: rtl/bpvx_zero_run.sv
module bpvx_zero_run #(
  parameter int THR_SHORT = 8,
  parameter int THR_LONG  = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic mark,
  input  logic sel_long,
  output logic exz_hit
);

  localparam int CW = $clog2(THR_LONG + 1);

  logic          armed_q;
  logic [CW-1:0] run_q;
  logic [CW-1:0] thr;
  logic [CW-1:0] run_nx;

  assign thr    = sel_long ? CW'(THR_LONG) : CW'(THR_SHORT);
  assign run_nx = run_q + 1'b1;
  assign exz_hit = bit_en && !mark && armed_q && (run_q < thr) && (run_nx == thr);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      run_q   <= '0;
    end else if (bit_en) begin
      if (mark) begin
        armed_q <= 1'b1;
        run_q   <= '0;
      end else if (armed_q && (run_q < thr)) begin
        run_q <= run_nx;
      end
    end
  end

  // R8: nothing is counted before the first mark
  assert_idle_until_mark_R8: assert property (@(posedge clk) disable iff (rst)
    (!armed_q) |-> (run_q == '0));
  // R7: a mark restarts the run
  assert_mark_restarts_R7: assert property (@(posedge clk) disable iff (rst)
    (bit_en && mark) |=> (run_q == '0 && armed_q));
  // R7: the count stops at the largest threshold
  assert_run_capped_R7: assert property (@(posedge clk) disable iff (rst)
    run_q <= CW'(THR_LONG));

endmodule

// File: rtl/bpvx_detect.sv
module bpvx_detect
  import bpvx_pkg::*;
#(
  parameter int LOOKAHEAD = 8,
  parameter int EXZ_SHORT = 8,
  parameter int EXZ_LONG  = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_en,
  input  logic       pos_in,
  input  logic       neg_in,
  input  logic [1:0] code_sel,
  input  logic       exz_16,
  input  logic       exz_to_lcv,
  output logic       bpv_o,
  output logic       exz_o,
  output logic       lcv_o
);

  sym_t sym_new;
  logic tail_viol;
  logic exz_hit;
  logic bpv_hit;

  bpvx_mark_class u_class (
    .clk    (clk),
    .rst    (rst),
    .bit_en (bit_en),
    .pos_in (pos_in),
    .neg_in (neg_in),
    .sym_o  (sym_new)
  );

  bpvx_sub_window #(.LOOKAHEAD(LOOKAHEAD)) u_window (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .code_sel  (code_sel),
    .sym_new   (sym_new),
    .tail_viol (tail_viol)
  );

  bpvx_zero_run #(.THR_SHORT(EXZ_SHORT), .THR_LONG(EXZ_LONG)) u_zeros (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .mark     (sym_new.mark),
    .sel_long (exz_16),
    .exz_hit  (exz_hit)
  );

  assign bpv_hit = bit_en & tail_viol;

  always_ff @(posedge clk) begin
    if (rst) begin
      bpv_o <= 1'b0;
      exz_o <= 1'b0;
      lcv_o <= 1'b0;
    end else begin
      bpv_o <= bpv_hit;
      exz_o <= exz_hit;
      lcv_o <= bpv_hit | (exz_hit & exz_to_lcv);
    end
  end

  // R10: strobes only follow an enabled edge
  assert_bpv_needs_en_R10: assert property (@(posedge clk) disable iff (rst)
    bpv_o |-> $past(bit_en));
  assert_exz_needs_en_R10: assert property (@(posedge clk) disable iff (rst)
    exz_o |-> $past(bit_en));
  // R6: excess zeros is raised by a zero bit time
  assert_exz_on_zero_R6: assert property (@(posedge clk) disable iff (rst)
    exz_o |-> $past(!pos_in && !neg_in));
  // R7: never two strobes back to back
  assert_exz_single_R7: assert property (@(posedge clk) disable iff (rst)
    exz_o |=> !exz_o);
  // R9: combined strobe has a source, and includes enabled zero-run events
  assert_lcv_source_R9: assert property (@(posedge clk) disable iff (rst)
    lcv_o |-> (bpv_o || exz_o));
  assert_lcv_follows_bpv_R9: assert property (@(posedge clk) disable iff (rst)
    bpv_o |-> lcv_o);
  assert_lcv_exz_R9: assert property (@(posedge clk) disable iff (rst)
    (exz_o && $past(exz_to_lcv)) |-> lcv_o);

endmodule

// File: tb/test_bpvx_detect.sv
`timescale 1ns/1ps
module test_bpvx_detect;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0;
  logic       pos_in = 1'b0;
  logic       neg_in = 1'b0;
  logic [1:0] code_sel = 2'd0;
  logic       exz_16 = 1'b0;
  logic       exz_to_lcv = 1'b0;
  logic       bpv_o, exz_o, lcv_o;

  always #5 clk = ~clk;

  bpvx_detect i_bpvx_detect (
    .clk(clk), .rst(rst), .bit_en(bit_en), .pos_in(pos_in), .neg_in(neg_in),
    .code_sel(code_sel), .exz_16(exz_16), .exz_to_lcv(exz_to_lcv),
    .bpv_o(bpv_o), .exz_o(exz_o), .lcv_o(lcv_o)
  );

  int total = 0;
  int failed = 0;
  int n_bpv = 0, n_exz = 0, n_lcv = 0, n_stray = 0;
  int bpol = 0;          // stimulus polarity: 0 none, 1 pos, 2 neg
  logic prev_en = 1'b0;
  logic done = 1'b0;

  always @(posedge clk) prev_en <= bit_en;

  always @(negedge clk) begin
    if (!rst) begin
      if (bpv_o) n_bpv++;
      if (exz_o) n_exz++;
      if (lcv_o) n_lcv++;
      if ((bpv_o || exz_o || lcv_o) && !prev_en) n_stray++;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] cs, input logic l16, input logic fold);
    @(negedge clk);
    rst = 1'b1; bit_en = 1'b0; pos_in = 1'b0; neg_in = 1'b0;
    code_sel = cs; exz_16 = l16; exz_to_lcv = fold;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    n_bpv = 0; n_exz = 0; n_lcv = 0;
    bpol = 0;
    #1;
  endtask

  task automatic send(input logic p, input logic n);
    @(negedge clk);
    pos_in = p; neg_in = n; bit_en = 1'b1;
    if (p && !n) bpol = 1;
    else if (n && !p) bpol = 2;
    @(negedge clk);
    bit_en = 1'b0; pos_in = 1'b0; neg_in = 1'b0;
    #1;
  endtask

  task automatic norm();   // alternating mark
    if (bpol == 1) send(1'b0, 1'b1); else send(1'b1, 1'b0);
  endtask
  task automatic same();   // violating mark
    if (bpol == 2) send(1'b0, 1'b1); else send(1'b1, 1'b0);
  endtask
  task automatic zero(input int k);
    for (int i = 0; i < k; i++) send(1'b0, 1'b0);
  endtask
  task automatic flush();
    for (int i = 0; i < 8; i++) norm();
  endtask

  task automatic t_reset_state();
    do_reset(2'd0, 1'b0, 1'b0);
    check("R10 bpv_o in reset", int'(bpv_o), 0);
    check("R10 exz_o in reset", int'(exz_o), 0);
    check("R10 lcv_o in reset", int'(lcv_o), 0);
  endtask

  task automatic t_ami_latency();
    do_reset(2'd0, 1'b0, 1'b0);
    send(1'b1, 1'b0);            // first mark, never a violation
    same();                      // violation
    for (int i = 0; i < 7; i++) norm();
    check("R1 no strobe before 8 bit times", n_bpv, 0);
    norm();
    check("R1 strobe after 8 bit times", n_bpv, 1);
    check("R9 lcv follows bpv", n_lcv, 1);
    zero(3); norm(); zero(2); norm(); flush();
    check("R1 alternating marks clean", n_bpv, 1);
  endtask

  task automatic t_double_rail();
    do_reset(2'd0, 1'b0, 1'b0);
    send(1'b1, 1'b0);
    send(1'b1, 1'b1);            // double rail; last polarity stays positive
    send(1'b0, 1'b1);            // alternating w.r.t. positive
    flush();
    check("R2 double rail reported once", n_bpv, 1);
  endtask

  task automatic eight_group();
    zero(3); same(); norm(); zero(1); same(); norm();
  endtask

  task automatic t_eight_sub();
    do_reset(2'd1, 1'b0, 1'b0);
    norm();
    eight_group();
    flush();
    check("R3 eight-zero group excused", n_bpv, 0);
    check("R3 no excess zeros", n_exz, 0);
    same(); flush();
    check("R3 plain violation still reported", n_bpv, 1);
  endtask

  task automatic t_ami_group();
    do_reset(2'd0, 1'b0, 1'b0);
    norm();
    eight_group();
    flush();
    check("R5 AMI reports both pulses", n_bpv, 2);
    do_reset(2'd3, 1'b0, 1'b0);
    norm();
    zero(3); same(); flush();
    check("R5 code 3 reports three-zero V", n_bpv, 1);
  endtask

  task automatic t_three_sub();
    do_reset(2'd2, 1'b0, 1'b0);
    norm();
    zero(3); same();             // 0,0,0,V
    norm(); zero(2); same();     // B,0,0,V
    flush();
    check("R4 three-zero groups excused", n_bpv, 0);
    norm(); zero(1); same(); flush();   // B,0,V is not a group
    check("R4 short group reported", n_bpv, 1);
  endtask

  task automatic t_exz8();
    do_reset(2'd0, 1'b0, 1'b1);
    norm();
    zero(7);
    check("R6 no strobe at 7 zeros", n_exz, 0);
    zero(1);
    check("R6 strobe at 8 zeros", n_exz, 1);
    check("R9 lcv includes exz when folded", n_lcv, 1);
    zero(10);
    check("R7 once per run", n_exz, 1);
    norm(); zero(8);
    check("R7 new run after mark", n_exz, 2);
  endtask

  task automatic t_exz16();
    do_reset(2'd0, 1'b1, 1'b0);
    norm();
    zero(15);
    check("R6 no strobe at 15 zeros", n_exz, 0);
    zero(1);
    check("R6 strobe at 16 zeros", n_exz, 1);
    check("R9 lcv excludes exz when not folded", n_lcv, 0);
  endtask

  task automatic t_leading_zeros();
    do_reset(2'd0, 1'b0, 1'b1);
    zero(20);
    check("R8 zeros before first mark ignored", n_exz, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failed++; total++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_ami_latency();
    t_double_rail();
    t_eight_sub();
    t_ami_group();
    t_three_sub();
    t_exz8();
    t_exz16();
    t_leading_zeros();
    check("R10 no strobe without enabled edge", n_stray, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule